// File: doc/BRIEF.md
# Multi-level interrupt priority resolver

This block sits beside a processor core and decides whether an interrupt should be taken, and at which priority. It keeps one pending bit and one enable bit for each interrupt line. Each line belongs to a priority level through a mask fixed at elaboration. A line is active when it is both pending and enabled. The block reports the highest level that holds an active line and is strictly above the level the core is running at. While such a level exists, it raises a request to the core.

Interrupt lines arrive as indexed events: an index, and a flag saying whether the line went high or low. A rising event marks the line pending. A falling event clears the pending bit only for lines configured as level-type. Edge-type lines stay pending until a write-one-to-clear port removes them. Compare-match pulses from cycle-counter comparators act as rising events on the lines mapped to them. A write port loads the whole enable word.

Default configuration: 24 lines, 7 levels, 5-bit event index. Lines 0-19 fall in four-line groups, with level = line/4 + 1. Lines 20-21 are level 6 and lines 22-23 are level 7. Odd-numbered lines are edge-type and even-numbered lines are level-type. Compare unit 0 drives line 23 and compare unit 1 drives line 13.

Top module: `irq_level_resolver`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `pend_bits`, `en_bits`, `pend_level` and `irq_req` are all zero.
- R2: `pend_level` is the highest level L with L > `cur_level` whose mask shares a bit with `pend_bits & en_bits`. It follows changes of the registers and of `cur_level` in the same cycle, without waiting for a clock edge.
- R3: When no level qualifies, including when every active line sits at or below `cur_level`, `pend_level` is 0.
- R4: `irq_req` is registered. After each clock edge it equals (`pend_level` != 0) as sampled at that edge.
- R5: A cycle with `ev_valid`=1, `ev_high`=1 and `ev_idx` below the line count sets the pending bit at bit position `ev_idx` at the next edge.
- R6: A cycle with `ev_valid`=1 and `ev_high`=0 clears the pending bit of a level-type (even) line. It leaves the pending bit of an edge-type (odd) line set.
- R7: An event whose `ev_idx` is at or above the line count (24..31 by default) changes no pending bit.
- R8: A pulse on `cmp_match[i]` sets the pending bit of the line mapped to compare unit i (unit 0 maps to line 23, unit 1 to line 13).
- R9: With `clr_we`=1, each 1 in `clr_mask` clears the matching pending bit if that line is edge-type. Level-type bits are left unchanged.
- R10: With `en_we`=1, `en_bits` takes the value of `en_wdata` at the next edge. Otherwise it holds.
- R11: When a line is both set (by an event or a compare match) and cleared in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | A line event is presented this cycle |
| ev_idx | input | 5 | Index of the line the event refers to |
| ev_high | input | 1 | 1: line asserted, 0: line deasserted |
| cmp_match | input | 2 | Compare-match pulses, one per compare unit |
| clr_we | input | 1 | Apply the write-one-to-clear mask |
| clr_mask | input | 24 | Pending bits to clear (edge-type lines only) |
| en_we | input | 1 | Load the enable register |
| en_wdata | input | 24 | New enable word |
| cur_level | input | 3 | Current interrupt level of the core |
| pend_bits | output | 24 | Pending register |
| en_bits | output | 24 | Enable register |
| pend_level | output | 3 | Highest qualifying level, 0 if none |
| irq_req | output | 1 | Registered interrupt request to the core |

## Verification
Events, compare pulses, clears and enable writes show up in `pend_bits` and `en_bits` one edge after the cycle in which they are presented. `pend_level` follows those registers and `cur_level` with no added cycle. `irq_req` lags `pend_level` by exactly one edge. The bench changes inputs half a nanosecond after each falling edge and compares every output at the next falling edge. It compares against a behavioural model whose registers update on the same rising edge. Because the bench only samples on falling edges, each result is read in the cycle it is due, never in the middle of an update.

// File: rtl/irq_resolver_pkg.sv
package irq_resolver_pkg;
  localparam int LVL_W = 3;
  typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/irq_pend_reg.sv
module irq_pend_reg #(
  parameter int NUM_LINES = 24,
  parameter int IDX_W     = 5,
  parameter int NUM_CMP   = 2,
  parameter logic [NUM_LINES-1:0]     EDGE_MASK = '0,
  parameter logic [NUM_CMP*IDX_W-1:0] CMP_LINE  = '0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ev_valid,
  input  logic [IDX_W-1:0]     ev_idx,
  input  logic                 ev_high,
  input  logic [NUM_CMP-1:0]   cmp_match,
  input  logic                 clr_we,
  input  logic [NUM_LINES-1:0] clr_mask,
  output logic [NUM_LINES-1:0] pend
);
  logic [NUM_LINES-1:0] cmp_set;
  logic [NUM_LINES-1:0] set_v;
  logic [NUM_LINES-1:0] drop_v;

  always_comb begin
    cmp_set = '0;
    for (int j = 0; j < NUM_CMP; j++) begin
      for (int i = 0; i < NUM_LINES; i++) begin
        if (cmp_match[j] && (CMP_LINE[j*IDX_W +: IDX_W] == IDX_W'(i)))
          cmp_set[i] = 1'b1;
      end
    end
  end

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_bit
    logic hit;
    assign hit       = ev_valid && (ev_idx == IDX_W'(i));
    assign set_v[i]  = (hit && ev_high) || cmp_set[i];
    if (EDGE_MASK[i]) begin : g_edge
      assign drop_v[i] = clr_we && clr_mask[i];
    end else begin : g_level
      assign drop_v[i] = hit && !ev_high;
    end
    always_ff @(posedge clk) begin
      if (rst)            pend[i] <= 1'b0;
      else if (set_v[i])  pend[i] <= 1'b1;
      else if (drop_v[i]) pend[i] <= 1'b0;
    end
  end

  AST_RISE_SETS: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && ev_high && (int'(ev_idx) < NUM_LINES)) |=> pend[$past(ev_idx)]); // R5
  AST_LEVEL_FALL_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && !ev_high && (int'(ev_idx) < NUM_LINES) && !EDGE_MASK[ev_idx]
     && (cmp_match == '0)) |=> !pend[$past(ev_idx)]); // R6
  AST_EDGE_FALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && !ev_high && (int'(ev_idx) < NUM_LINES) && EDGE_MASK[ev_idx]
     && pend[ev_idx] && !clr_we) |=> pend[$past(ev_idx)]); // R6
  AST_OOR_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && (int'(ev_idx) >= NUM_LINES) && (cmp_match == '0) && !clr_we)
    |=> $stable(pend)); // R7
  AST_CLR_EDGE_ONLY: assert property (@(posedge clk) disable iff (rst)
    (clr_we && !ev_valid && (cmp_match == '0))
    |=> (((pend & EDGE_MASK & $past(clr_mask)) == '0)
         && ((pend & ~EDGE_MASK) == $past(pend & ~EDGE_MASK)))); // R9
  AST_SET_BEATS_CLR: assert property (@(posedge clk) disable iff (rst)
    (clr_we && !ev_valid) |=> ((pend & $past(cmp_set)) == $past(cmp_set))); // R11
endmodule

// File: rtl/irq_level_scan.sv
module irq_level_scan
  import irq_resolver_pkg::*;
#(
  parameter int NUM_LINES  = 24,
  parameter int NUM_LEVELS = 7,
  parameter logic [NUM_LEVELS*NUM_LINES-1:0] LEVEL_MASKS = '0
) (
  input  logic [NUM_LINES-1:0] active,
  input  lvl_t                 floor_lvl,
  output lvl_t                 best_lvl
);
  logic [NUM_LEVELS:1] lvl_hit;

  for (genvar l = 1; l <= NUM_LEVELS; l++) begin : g_lvl
    assign lvl_hit[l] = (l > int'(floor_lvl))
                        && ((LEVEL_MASKS[(l-1)*NUM_LINES +: NUM_LINES] & active) != '0);
  end

  always_comb begin
    logic found;
    found    = 1'b0;
    best_lvl = '0;
    for (int l = NUM_LEVELS; l >= 1; l--) begin
      if (!found && lvl_hit[l]) begin
        best_lvl = lvl_t'(l);
        found    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_level_resolver.sv
module irq_level_resolver
  import irq_resolver_pkg::*;
#(
  parameter int NUM_LINES  = 24,
  parameter int NUM_LEVELS = 7,
  parameter int IDX_W      = 5,
  parameter int NUM_CMP    = 2,
  parameter logic [NUM_LEVELS*NUM_LINES-1:0] LEVEL_MASKS =
    {24'hC00000, 24'h300000, 24'h0F0000, 24'h00F000,
     24'h000F00, 24'h0000F0, 24'h00000F},
  parameter logic [NUM_LINES-1:0]     EDGE_MASK = 24'hAAAAAA,
  parameter logic [NUM_CMP*IDX_W-1:0] CMP_LINE  = {5'd13, 5'd23}
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ev_valid,
  input  logic [IDX_W-1:0]     ev_idx,
  input  logic                 ev_high,
  input  logic [NUM_CMP-1:0]   cmp_match,
  input  logic                 clr_we,
  input  logic [NUM_LINES-1:0] clr_mask,
  input  logic                 en_we,
  input  logic [NUM_LINES-1:0] en_wdata,
  input  logic [LVL_W-1:0]     cur_level,
  output logic [NUM_LINES-1:0] pend_bits,
  output logic [NUM_LINES-1:0] en_bits,
  output logic [LVL_W-1:0]     pend_level,
  output logic                 irq_req
);
  logic [NUM_LINES-1:0] en_q;
  logic                 req_q;

  irq_pend_reg #(
    .NUM_LINES(NUM_LINES), .IDX_W(IDX_W), .NUM_CMP(NUM_CMP),
    .EDGE_MASK(EDGE_MASK), .CMP_LINE(CMP_LINE)
  ) u_pend (
    .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_idx(ev_idx),
    .ev_high(ev_high), .cmp_match(cmp_match), .clr_we(clr_we),
    .clr_mask(clr_mask), .pend(pend_bits)
  );

  always_ff @(posedge clk) begin
    if (rst)        en_q <= '0;
    else if (en_we) en_q <= en_wdata;
  end
  assign en_bits = en_q;

  irq_level_scan #(
    .NUM_LINES(NUM_LINES), .NUM_LEVELS(NUM_LEVELS), .LEVEL_MASKS(LEVEL_MASKS)
  ) u_scan (
    .active(pend_bits & en_q), .floor_lvl(cur_level), .best_lvl(pend_level)
  );

  always_ff @(posedge clk) begin
    if (rst) req_q <= 1'b0;
    else     req_q <= (pend_level != '0);
  end
  assign irq_req = req_q;

  AST_LVL_ABOVE_CUR: assert property (@(posedge clk) disable iff (rst)
    (pend_level != '0) |-> (pend_level > cur_level)); // R2
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    ((pend_bits & en_q) == '0) |-> (pend_level == '0)); // R3
  AST_REQ_RISE: assert property (@(posedge clk) disable iff (rst)
    (pend_level != '0) |=> irq_req); // R4
  AST_REQ_FALL: assert property (@(posedge clk) disable iff (rst)
    (pend_level == '0) |=> !irq_req); // R4
  AST_EN_LOAD: assert property (@(posedge clk) disable iff (rst)
    en_we |=> (en_bits == $past(en_wdata))); // R10
endmodule

// File: tb/irq_level_resolver_test.sv
`timescale 1ns/1ps
module irq_level_resolver_test;
  localparam int NL = 24;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ev_valid = 1'b0;
  logic [4:0]    ev_idx = '0;
  logic          ev_high = 1'b0;
  logic [1:0]    cmp_match = '0;
  logic          clr_we = 1'b0;
  logic [NL-1:0] clr_mask = '0;
  logic          en_we = 1'b0;
  logic [NL-1:0] en_wdata = '0;
  logic [2:0]    cur_level = '0;
  logic [NL-1:0] pend_bits, en_bits;
  logic [2:0]    pend_level;
  logic          irq_req;

  int vectors = 0;
  int errors  = 0;
  bit checking = 0;

  irq_level_resolver uut (
    .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_idx(ev_idx), .ev_high(ev_high),
    .cmp_match(cmp_match), .clr_we(clr_we), .clr_mask(clr_mask), .en_we(en_we),
    .en_wdata(en_wdata), .cur_level(cur_level), .pend_bits(pend_bits),
    .en_bits(en_bits), .pend_level(pend_level), .irq_req(irq_req)
  );

  always #2.5 clk = ~clk;

  // behavioural model
  bit m_pend [NL];
  bit m_en   [NL];
  bit m_req;

  function automatic int line_level(int ln);
    if (ln < 20) return ln / 4 + 1;
    if (ln < 22) return 6;
    return 7;
  endfunction

  function automatic int model_level(int cur);
    int best = 0;
    for (int ln = 0; ln < NL; ln++)
      if (m_pend[ln] && m_en[ln] && line_level(ln) > cur && line_level(ln) > best)
        best = line_level(ln);
    return best;
  endfunction

  function automatic logic [NL-1:0] pack(input bit a [NL]);
    logic [NL-1:0] v;
    for (int ln = 0; ln < NL; ln++) v[ln] = a[ln];
    return v;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int ln = 0; ln < NL; ln++) begin m_pend[ln] = 0; m_en[ln] = 0; end
      m_req = 0;
    end else begin
      bit nxt [NL];
      m_req = (model_level(int'(cur_level)) != 0);
      for (int ln = 0; ln < NL; ln++) begin
        bit odd_ln, setb, clrb;
        odd_ln = (ln % 2) == 1;
        setb = (ev_valid && ev_high && int'(ev_idx) == ln)
            || (cmp_match[0] && ln == 23) || (cmp_match[1] && ln == 13);
        clrb = odd_ln ? (clr_we && clr_mask[ln])
                      : (ev_valid && !ev_high && int'(ev_idx) == ln);
        nxt[ln] = setb ? 1'b1 : (clrb ? 1'b0 : m_pend[ln]);
      end
      for (int ln = 0; ln < NL; ln++) m_pend[ln] = nxt[ln];
      if (en_we) for (int ln = 0; ln < NL; ln++) m_en[ln] = en_wdata[ln];
    end
  end

  task automatic cmp(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (checking) begin
      cmp("R5 pend_bits", 32'(pend_bits), 32'(pack(m_pend)));
      cmp("R10 en_bits", 32'(en_bits), 32'(pack(m_en)));
      cmp("R2 pend_level", 32'(pend_level), 32'(model_level(int'(cur_level))));
      cmp("R4 irq_req", 32'(irq_req), 32'(m_req));
    end
  end

  task automatic tick();
    @(negedge clk);
    #0.5;
  endtask

  task automatic line_event(int idx, bit hi);
    ev_valid = 1'b1; ev_idx = 5'(idx); ev_high = hi;
    tick();
    ev_valid = 1'b0;
  endtask

  initial begin : watchdog
    #500000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) tick();
    cmp("R1 reset pend", 32'(pend_bits), 0);
    cmp("R1 reset req", 32'(irq_req), 0);
    rst = 1'b0;
    tick();
    cmp("R1 after reset level", 32'(pend_level), 0);
    cmp("R1 after reset en", 32'(en_bits), 0);
    checking = 1;

    en_we = 1'b1; en_wdata = 24'hFFFFFF; tick(); en_we = 1'b0;
    cmp("R10 enable load", 32'(en_bits), 32'h00FFFFFF);

    line_event(2, 1);
    cmp("R5 line 2 pending", 32'(pend_bits), 32'h4);
    cmp("R2 level 1", 32'(pend_level), 1);
    tick();
    cmp("R4 request raised", 32'(irq_req), 1);

    cur_level = 3'd1; #0.1;
    cmp("R3 at threshold", 32'(pend_level), 0);
    tick();
    cmp("R4 request dropped", 32'(irq_req), 0);
    cur_level = 3'd0;

    line_event(20, 1);
    cmp("R2 level 6", 32'(pend_level), 6);
    line_event(20, 0);
    cmp("R6 level-type cleared", 32'(pend_bits[20]), 0);
    line_event(21, 1);
    line_event(21, 0);
    cmp("R6 edge-type held", 32'(pend_bits[21]), 1);

    clr_we = 1'b1; clr_mask = 24'h200004; tick(); clr_we = 1'b0;
    cmp("R9 clear edge and skip level", 32'(pend_bits), 32'h4);

    line_event(30, 1);
    line_event(31, 0);
    cmp("R7 out of range ignored", 32'(pend_bits), 32'h4);

    cmp_match = 2'b01; tick(); cmp_match = 2'b00;
    cmp("R8 unit 0 to line 23", 32'(pend_bits), 32'h800004);
    cmp("R8 level 7", 32'(pend_level), 7);
    cmp_match = 2'b10; tick(); cmp_match = 2'b00;
    cmp("R8 unit 1 to line 13", 32'(pend_bits[13]), 1);

    cmp_match = 2'b01; clr_we = 1'b1; clr_mask = 24'h800000; tick();
    cmp_match = 2'b00; clr_we = 1'b0;
    cmp("R11 set wins over clear", 32'(pend_bits[23]), 1);

    en_we = 1'b1; en_wdata = 24'h000004; tick(); en_we = 1'b0;
    cmp("R10 R2 masked by enable", 32'(pend_level), 1);

    for (int n = 0; n < 600; n++) begin
      ev_valid  = ($urandom_range(0, 1) == 1);
      ev_idx    = 5'($urandom_range(0, 31));
      ev_high   = ($urandom_range(0, 2) != 0);
      cmp_match = ($urandom_range(0, 7) == 0) ? 2'($urandom_range(1, 3)) : 2'b00;
      clr_we    = ($urandom_range(0, 3) == 0);
      clr_mask  = NL'($urandom());
      en_we     = ($urandom_range(0, 15) == 0);
      en_wdata  = NL'($urandom());
      cur_level = 3'($urandom_range(0, 7));
      tick();
    end
    ev_valid = 0; cmp_match = 0; clr_we = 0; en_we = 0;
    tick();
    checking = 0;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule